// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column addresses of one synchronous DRAM burst, one per clock. A start pulse carries the first column, the length code and the ordering request. The first column is presented in the same cycle as the start pulse. The following columns come out on consecutive clocks. Each output column carries a valid flag, and the final column of a fixed-length burst also carries a last flag.

Columns can be visited in two orders. In sequential order the column counts upward and wraps inside the block of columns aligned to the burst length. In interleaved order the start column is XORed with a running count. A full-page burst walks every column of the row in sequential order, wraps from the top column back to zero, and ends only when a stop or a new start arrives. A new start in the middle of a burst drops the rest of that burst and begins again from the new column.

The controller that decodes commands drives this block. It reads `col_out` into the column path of the array.

Top module: `col_burst_gen`

## Requirements
- R1: After synchronous reset, and until the first start, `col_valid`, `col_last` and `mode_err` are 0 and `col_out` is 0.
- R2: In a cycle with `start` high, `col_valid` is 1 and `col_out` equals `start_col`. The rest of the burst follows on consecutive clocks with `col_valid` high and no gaps.
- R3: With `ilv_req` = 0 and a fixed length L, column k of the burst (k counted from 0) is the start column with its low log2(L) bits replaced by (start + k) mod L. For example, L=4 from column 1 gives 1, 2, 3, 0.
- R4: With `ilv_req` = 1 and a fixed length L, column k is the start column XOR k. For example, L=8 from column 2 gives 2, 3, 0, 1, 6, 7, 4, 5.
- R5: The length code `len_sel` selects the length as follows: 0 gives 1 column, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a full page. Codes 4, 5 and 6 give 1 column.
- R6: `col_last` is 1 exactly on the final column of a fixed-length burst. In the following cycle `col_valid` is 0 unless a new start arrives.
- R7: A full-page burst outputs (start + k) mod 256 on every clock, keeps running past 256 columns, and never raises `col_last`.
- R8: A start that arrives during a burst outputs the new column in that cycle and continues with a complete burst of the newly requested length. No column of the earlier burst is output after it.
- R9: A `stop` in a cycle with a burst and no start still lets that cycle's column out, and `col_valid` is 0 from the next clock. A stop with no burst running has no effect. When start and stop arrive in the same cycle, the start wins and the burst runs.
- R10: Interleaved ordering requested together with a full page runs as a sequential full page. `mode_err` is 1 in every valid cycle of that burst and 0 in every other cycle.
- R11: Column bits above the burst boundary keep the start column's values throughout a burst.
- R12: `len_sel` and `ilv_req` are sampled only with `start`. Changing them during a burst does not alter its columns or its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a burst at `start_col`; interrupts any burst in progress |
| start_col | input | 8 | First column of the burst |
| len_sel | input | 3 | Length code, sampled with `start` |
| ilv_req | input | 1 | 1 requests interleaved order, 0 sequential; sampled with `start` |
| stop | input | 1 | Ends the running burst after the current column |
| col_out | output | 8 | Current column; 0 when not valid |
| col_valid | output | 1 | `col_out` holds a burst column |
| col_last | output | 1 | Final column of a fixed-length burst |
| mode_err | output | 1 | Valid cycle of a burst whose interleaved full-page request was turned into sequential order |

## Verification
The assertions assume that `start` and `stop` stay low while reset is high, and that every input is steady at the rising edge. The bench changes its inputs only half a cycle away from that edge and holds start low during reset. The properties assume nothing about the data values themselves. The directed scenarios cover every length code, both orderings, a full-page wrap, and the start-against-stop collisions. They also include mode inputs that change in the middle of a burst.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    localparam int COL_W  = 8;
    localparam int LSEL_W = 3;
    localparam int MAX_FIXED_LOG = 3;
    localparam logic [LSEL_W-1:0] LSEL_PAGE = 3'd7;

    typedef logic [COL_W-1:0]  col_t;
    typedef logic [LSEL_W-1:0] lsel_t;

    typedef struct packed {
        col_t mask;   // low bits that move within the burst
        logic full;   // full-page burst, no natural end
        logic ilv;    // interleaved ordering in effect
        logic err;    // illegal combination was requested
    } mode_t;

    function automatic col_t seq_col(col_t base, col_t idx, col_t mask);
        return (base & ~mask) | ((base + idx) & mask);
    endfunction

    function automatic col_t ilv_col(col_t base, col_t idx, col_t mask);
        return base ^ (idx & mask);
    endfunction

endpackage

// File: rtl/bcg_mode_dec.sv
module bcg_mode_dec
    import bcg_pkg::*;
(
    input  lsel_t len_sel,
    input  logic  ilv_req,
    output mode_t mode
);
    logic full;
    logic fixed_ok;

    assign full     = (len_sel == LSEL_PAGE);
    assign fixed_ok = (int'(len_sel) <= MAX_FIXED_LOG);

    always_comb begin
        mode = '0;
        mode.full = full;
        for (int b = 0; b < COL_W; b++) begin
            if (full)
                mode.mask[b] = 1'b1;
            else if (fixed_ok)
                mode.mask[b] = (b < int'(len_sel));
            else
                mode.mask[b] = 1'b0;
        end
        mode.ilv = ilv_req & ~full;
        mode.err = ilv_req & full;
    end
endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map
    import bcg_pkg::*;
(
    input  col_t  base,
    input  col_t  idx,
    input  mode_t mode,
    output col_t  addr,
    output logic  at_end
);
    assign addr   = mode.ilv ? ilv_col(base, idx, mode.mask)
                             : seq_col(base, idx, mode.mask);
    assign at_end = ~mode.full & (idx == mode.mask);
endmodule

// File: rtl/bcg_seq_ctl.sv
module bcg_seq_ctl
    import bcg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  stop,
    input  col_t  start_col,
    input  mode_t mode_live,
    input  logic  at_end,
    output logic  active,
    output col_t  base_q,
    output col_t  idx_q,
    output mode_t mode_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            base_q <= '0;
            idx_q  <= '0;
            mode_q <= '0;
        end else if (start) begin
            base_q <= start_col;
            mode_q <= mode_live;
            idx_q  <= col_t'(1);
            active <= ~at_end;
        end else if (active) begin
            if (stop || at_end)
                active <= 1'b0;
            else
                idx_q <= idx_q + col_t'(1);
        end
    end

    AST_IDX_IN_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (active && !mode_q.full) |-> ((idx_q & ~mode_q.mask) == '0)) else $error("idx"); // R5
endmodule

// File: rtl/col_burst_gen.sv
module col_burst_gen
    import bcg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] start_col,
    input  logic [2:0] len_sel,
    input  logic       ilv_req,
    input  logic       stop,
    output logic [7:0] col_out,
    output logic       col_valid,
    output logic       col_last,
    output logic       mode_err
);
    mode_t mode_live;
    mode_t mode_q;
    mode_t mode_sel;
    col_t  base_q;
    col_t  idx_q;
    col_t  base_sel;
    col_t  idx_sel;
    col_t  addr;
    logic  active;
    logic  at_end;

    bcg_mode_dec u_dec (
        .len_sel (len_sel),
        .ilv_req (ilv_req),
        .mode    (mode_live)
    );

    assign mode_sel = start ? mode_live : mode_q;
    assign base_sel = start ? start_col : base_q;
    assign idx_sel  = start ? '0 : idx_q;

    bcg_addr_map u_map (
        .base   (base_sel),
        .idx    (idx_sel),
        .mode   (mode_sel),
        .addr   (addr),
        .at_end (at_end)
    );

    bcg_seq_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .stop      (stop),
        .start_col (start_col),
        .mode_live (mode_live),
        .at_end    (at_end),
        .active    (active),
        .base_q    (base_q),
        .idx_q     (idx_q),
        .mode_q    (mode_q)
    );

    assign col_valid = start | active;
    assign col_out   = col_valid ? addr : '0;
    assign col_last  = col_valid & at_end;
    assign mode_err  = col_valid & mode_sel.err;

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (rst)
        (stop && !start && col_valid) |=> (!col_valid || start)) else $error("stop"); // R9
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
        col_last |=> (!col_valid || start)) else $error("last"); // R6
    AST_NO_GAP: assert property (@(posedge clk) disable iff (rst)
        (col_valid && !col_last && !stop) |=> col_valid) else $error("gap"); // R2
    AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (rst)
        (active && !start && mode_q.full) |-> !col_last) else $error("page last"); // R7
    AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (rst)
        (col_valid && !start && $past(col_valid) && !$past(rst))
            |-> (((col_out ^ $past(col_out)) & ~mode_q.mask) == '0)) else $error("upper"); // R11
endmodule

// File: tb/col_burst_gen_bench.sv
module col_burst_gen_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] start_col = '0;
    logic [2:0] len_sel = '0;
    logic       ilv_req = 1'b0;
    logic       stop = 1'b0;
    logic [7:0] col_out;
    logic       col_valid;
    logic       col_last;
    logic       mode_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    col_burst_gen u_col_burst_gen (
        .clk(clk), .rst(rst), .start(start), .start_col(start_col),
        .len_sel(len_sel), .ilv_req(ilv_req), .stop(stop),
        .col_out(col_out), .col_valid(col_valid), .col_last(col_last),
        .mode_err(mode_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input bit s, input logic [7:0] c, input logic [2:0] l,
                         input bit il, input bit sp);
        start = s; start_col = c; len_sel = l; ilv_req = il; stop = sp;
        #1;
    endtask

    task automatic adv();
        @(negedge clk);
    endtask

    function automatic int len_of(input logic [2:0] l);
        if (l == 3'd7) return 256;
        if (l <= 3'd3) return 1 << l;
        return 1;
    endfunction

    function automatic int model_col(input int base, input int k, input int len, input bit il);
        if (len == 256) return (base + k) % 256;
        if (il) return base ^ k;
        return base - (base % len) + ((base % len) + k) % len;
    endfunction

    task automatic expect_out(input bit v, input int c, input bit last, input bit err,
                              input string tag);
        chk(col_valid === v, {tag, " valid"}, col_valid, v);
        if (v) chk(col_out === 8'(c), {tag, " col"}, col_out, c);
        chk(col_last === last, {tag, " last"}, col_last, last);
        chk(mode_err === err, {tag, " err"}, mode_err, err);
    endtask

    task automatic run_fixed(input logic [7:0] c, input logic [2:0] l, input bit il,
                             input string tag);
        int n;
        n = len_of(l);
        for (int k = 0; k < n; k++) begin
            drive(k == 0, c, l, il, 1'b0);
            expect_out(1'b1, model_col(c, k, n, il), k == n - 1, 1'b0, tag);
            adv();
        end
        drive(1'b0, 8'h00, 3'd0, 1'b0, 1'b0);
        expect_out(1'b0, 0, 1'b0, 1'b0, {tag, " after"});
        adv();
    endtask

    task automatic t_reset();
        expect_out(1'b0, 0, 1'b0, 1'b0, "R1 reset");
        chk(col_out === 8'h00, "R1 col zero", col_out, 0);
    endtask

    task automatic t_sequential();
        int ex[4] = '{1, 2, 3, 0};
        for (int k = 0; k < 4; k++) begin
            drive(k == 0, 8'h01, 3'd2, 1'b0, 1'b0);
            expect_out(1'b1, ex[k], k == 3, 1'b0, "R3 R2 seq4");
            adv();
        end
        drive(1'b0, 8'h00, 3'd0, 1'b0, 1'b0);
        expect_out(1'b0, 0, 1'b0, 1'b0, "R6 end seq4");
        adv();
        run_fixed(8'hA5, 3'd3, 1'b0, "R11 R3 seq8 upper");
    endtask

    task automatic t_interleave();
        int ex[8] = '{2, 3, 0, 1, 6, 7, 4, 5};
        for (int k = 0; k < 8; k++) begin
            drive(k == 0, 8'h02, 3'd3, 1'b1, 1'b0);
            expect_out(1'b1, ex[k], k == 7, 1'b0, "R4 ilv8");
            adv();
        end
        run_fixed(8'h3E, 3'd2, 1'b1, "R4 R11 ilv4");
    endtask

    task automatic t_lengths();
        for (int l = 0; l < 7; l++) begin
            run_fixed(8'h5B, 3'(l), 1'b0, "R5 length seq");
            run_fixed(8'hC6, 3'(l), 1'b1, "R5 length ilv");
        end
    endtask

    task automatic t_page(input bit il);
        string tag;
        tag = il ? "R10 page err" : "R7 page";
        for (int k = 0; k < 260; k++) begin
            drive(k == 0, 8'd250, 3'd7, il, 1'b0);
            expect_out(1'b1, (250 + k) % 256, 1'b0, il, tag);
            adv();
        end
        drive(1'b0, 8'h00, 3'd0, 1'b0, 1'b1);
        expect_out(1'b1, (250 + 260) % 256, 1'b0, il, "R9 page stop cycle");
        adv();
        drive(1'b0, 8'h00, 3'd0, 1'b0, 1'b0);
        expect_out(1'b0, 0, 1'b0, 1'b0, "R9 R10 page stopped");
        adv();
    endtask

    task automatic t_interrupt();
        int ex[4] = '{8'h23, 8'h20, 8'h21, 8'h22};
        for (int k = 0; k < 3; k++) begin
            drive(k == 0, 8'h10, 3'd3, 1'b0, 1'b0);
            expect_out(1'b1, 8'h10 + k, 1'b0, 1'b0, "R8 first burst");
            adv();
        end
        for (int k = 0; k < 4; k++) begin
            drive(k == 0, 8'h23, 3'd2, 1'b0, 1'b0);
            expect_out(1'b1, ex[k], k == 3, 1'b0, "R8 restart");
            adv();
        end
        drive(1'b0, 8'h00, 3'd0, 1'b0, 1'b0);
        expect_out(1'b0, 0, 1'b0, 1'b0, "R8 end");
        adv();
    endtask

    task automatic t_stop();
        drive(1'b1, 8'h05, 3'd3, 1'b1, 1'b0);
        expect_out(1'b1, 5, 1'b0, 1'b0, "R9 stop burst");
        adv();
        drive(1'b0, 8'h00, 3'd0, 1'b0, 1'b0);
        expect_out(1'b1, 4, 1'b0, 1'b0, "R9 stop burst");
        adv();
        drive(1'b0, 8'h00, 3'd0, 1'b0, 1'b1);
        expect_out(1'b1, 7, 1'b0, 1'b0, "R9 stop cycle");
        adv();
        drive(1'b0, 8'h00, 3'd0, 1'b0, 1'b1);
        expect_out(1'b0, 0, 1'b0, 1'b0, "R9 after stop");
        adv();
        drive(1'b0, 8'h00, 3'd0, 1'b0, 1'b0);
        expect_out(1'b0, 0, 1'b0, 1'b0, "R9 idle stop no effect");
        adv();
        for (int k = 0; k < 2; k++) begin
            drive(k == 0, 8'h40, 3'd1, 1'b0, k == 0);
            expect_out(1'b1, 8'h40 + k, k == 1, 1'b0, "R9 start beats stop");
            adv();
        end
        drive(1'b0, 8'h00, 3'd0, 1'b0, 1'b0);
        expect_out(1'b0, 0, 1'b0, 1'b0, "R9 start beats stop end");
        adv();
    endtask

    task automatic t_hold();
        int ex[4] = '{6, 7, 4, 5};
        for (int k = 0; k < 4; k++) begin
            if (k == 0) drive(1'b1, 8'h06, 3'd2, 1'b0, 1'b0);
            else        drive(1'b0, 8'hFF, 3'd7, 1'b1, 1'b0);
            expect_out(1'b1, ex[k], k == 3, 1'b0, "R12 hold mode");
            adv();
        end
        drive(1'b0, 8'h00, 3'd3, 1'b1, 1'b0);
        expect_out(1'b0, 0, 1'b0, 1'b0, "R12 hold end");
        adv();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        drive(1'b0, 8'h00, 3'd0, 1'b0, 1'b0);
        t_reset();
        adv();
        t_sequential();
        t_interleave();
        t_lengths();
        t_page(1'b0);
        t_page(1'b1);
        t_interrupt();
        t_stop();
        t_hold();
        done = 1'b1;
        summary();
    end
endmodule